// File: doc/BRIEF.md
# Dual NAND Read-Path Emulator

This block stands in for two small NAND-style flash chips that share one parallel control and data port. Each chip has its own active-low select and its own ready bit. Each chip runs its own command and address state machine. A host that toggles the port as it would for real parts can pick a read mode, send a three-byte address and then pull bytes out one strobe at a time. The byte address moves forward by one after each read.

Each chip keeps its contents in a small internal byte array, whose size is set by a parameter that must be a power of two. The array is erased to 0xFF by reset and can be filled through a side write port for testing. The computed byte address is reduced modulo the array size. The chips never report busy. Program, erase and status commands are not modelled. Bad commands and misplaced address bytes set a sticky per-chip error bit and change nothing else.

Each chip's state machine has four states. `ST_IDLE` is entered on reset and on command 0xFF. Command 0x00 moves to `ST_MODE1`, 0x01 to `ST_MODE2` and 0x50 to `ST_MODE3`, from any state. Each of these three commands also restarts the address byte count.

Top module: `nand_pair_emu`

## Requirements
- R1: Port bit positions are: data byte on bits 7:0, chip-0 select (active low) on bit 8, chip-1 select (active low) on bit 9, read strobe on bit 10, write strobe on bit 11, address latch on bit 12, command latch on bit 13. Ready bits for chip 0 and chip 1 are `port_out`/`port_oe` bits 14 and 15. After reset `port_oe` is all zero and `err` is zero.
- R2: Chip 0 is addressed whenever bit 8 is low, even if bit 9 is also low. Chip 1 is addressed when bit 8 is high and bit 9 is low. With both high, all strobes leave both chips untouched.
- R3: While a chip is addressed and both strobes are high, that chip's ready bit turns to output direction, always driven high, and the data byte direction returns to input (`port_oe[7:0]` = 0).
- R4: On a falling write strobe with the command latch high, the data byte is taken as a command: 0x00, 0x01 and 0x50 select read modes 1, 2 and 3, and 0xFF returns to idle.
- R5: On a falling write strobe with the command latch low and the address latch high, a read-mode chip takes an address byte. The first byte sets the column, plus 0x100 in mode 2 or 0x200 in mode 3. The second byte adds byte×135168. The third adds byte×528. The result is taken modulo the array size (1024 by default).
- R6: On a falling read strobe with both latches low, the byte at the current address appears on `port_out[7:0]`, `port_oe[7:0]` becomes 0xFF, and the address increases by one.
- R7: Reset fills every array location with 0xFF, and the side write port stores a byte into the chosen chip at the chosen location.
- R8: An unknown command, an address byte in idle, or a fourth address byte sets that chip's bit of `err` sticky until reset and leaves the mode and address unchanged.
- R9: Commands, addresses and reads aimed at one chip do not change the other chip's mode or address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| port_in | input | 14 | Sampled port bits 13:0 (data, selects, strobes, latches) |
| port_out | output | 16 | Values driven onto the port: read byte and ready bits |
| port_oe | output | 16 | Per-bit output direction for the port |
| err | output | 2 | Sticky error bit per chip |
| ld_en | input | 1 | Side write enable |
| ld_chip | input | 1 | Side write chip select |
| ld_addr | input | AW | Side write byte location |
| ld_data | input | 8 | Side write byte |

## Verification
A wrong mode or column offset inside a chip stays hidden until the next read strobe. It then shows as a wrong byte on `port_out[7:0]`, two clock edges after the strobe falls. A lost address increment shows as a repeated byte on the next read. Any error-path slip shows on `err` two edges after the offending strobe. It can also show later as a read from an unexpected location. Preloaded values are chosen so that each wrong location returns a different byte.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;
    localparam int BIT_CE0 = 8;
    localparam int BIT_CE1 = 9;
    localparam int BIT_RE  = 10;
    localparam int BIT_WE  = 11;
    localparam int BIT_ALE = 12;
    localparam int BIT_CLE = 13;

    localparam logic [13:0] PORT_REST = 14'h0F00;

    localparam logic [7:0] CMD_IDLE = 8'hFF;
    localparam logic [7:0] CMD_RD1  = 8'h00;
    localparam logic [7:0] CMD_RD2  = 8'h01;
    localparam logic [7:0] CMD_RD3  = 8'h50;

    localparam int unsigned PAGE_BYTES    = 528;
    localparam int unsigned PAGE_ROW_SPAN = PAGE_BYTES * 256;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MODE1,
        ST_MODE2,
        ST_MODE3
    } rd_state_e;
endpackage

// File: rtl/nand_port_decode.sv
module nand_port_decode
    import nand_emu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [13:0] port_in,
    output logic [1:0]  cmd_stb,
    output logic [1:0]  addr_stb,
    output logic [1:0]  rd_stb,
    output logic [1:0]  idle_stb,
    output logic [7:0]  bus_byte
);
    logic [13:0] smp_q;
    logic        we_q;
    logic        re_q;
    logic [1:0]  sel;
    logic        we_fall;
    logic        re_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= PORT_REST;
            we_q  <= 1'b1;
            re_q  <= 1'b1;
        end else begin
            smp_q <= port_in;
            we_q  <= smp_q[BIT_WE];
            re_q  <= smp_q[BIT_RE];
        end
    end

    always_comb begin
        sel = 2'b00;
        if (!smp_q[BIT_CE0]) begin
            sel = 2'b01;
        end else if (!smp_q[BIT_CE1]) begin
            sel = 2'b10;
        end
    end

    assign we_fall  = we_q & ~smp_q[BIT_WE];
    assign re_fall  = re_q & ~smp_q[BIT_RE];
    assign bus_byte = smp_q[7:0];

    assign cmd_stb  = sel & {2{we_fall & smp_q[BIT_CLE]}};
    assign addr_stb = sel & {2{we_fall & ~smp_q[BIT_CLE] & smp_q[BIT_ALE]}};
    assign rd_stb   = sel & {2{re_fall & ~smp_q[BIT_CLE] & ~smp_q[BIT_ALE]}};
    assign idle_stb = sel & {2{smp_q[BIT_RE] & smp_q[BIT_WE]}};
endmodule

// File: rtl/nand_chip_ctrl.sv
module nand_chip_ctrl
    import nand_emu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic              addr_stb,
    input  logic              rd_stb,
    input  logic [7:0]        bus_byte,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);
    localparam logic [1:0]        LAST_CYC = 2'd3;
    localparam logic [ADDR_W-1:0] HI_W     = ADDR_W'(PAGE_ROW_SPAN);
    localparam logic [ADDR_W-1:0] LO_W     = ADDR_W'(PAGE_BYTES);

    rd_state_e         st_q, st_n;
    logic [1:0]        cyc_q, cyc_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              err_q, err_n;

    function automatic logic [ADDR_W-1:0] col_offset(input rd_state_e s);
        logic [ADDR_W-1:0] off;
        unique case (s)
            ST_MODE2: off = ADDR_W'(32'h100);
            ST_MODE3: off = ADDR_W'(32'h200);
            default:  off = '0;
        endcase
        return off;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cyc_q  <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            cyc_q  <= cyc_n;
            addr_q <= addr_n;
            err_q  <= err_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        cyc_n  = cyc_q;
        addr_n = addr_q;
        err_n  = err_q;
        if (cmd_stb) begin
            unique case (bus_byte)
                CMD_IDLE: st_n = ST_IDLE;
                CMD_RD1: begin st_n = ST_MODE1; cyc_n = '0; end
                CMD_RD2: begin st_n = ST_MODE2; cyc_n = '0; end
                CMD_RD3: begin st_n = ST_MODE3; cyc_n = '0; end
                default: err_n = 1'b1;
            endcase
        end else if (addr_stb) begin
            if (st_q == ST_IDLE || cyc_q == LAST_CYC) begin
                err_n = 1'b1;
            end else begin
                unique case (cyc_q)
                    2'd0:    addr_n = ADDR_W'(bus_byte) | col_offset(st_q);
                    2'd1:    addr_n = addr_q + ADDR_W'(bus_byte) * HI_W;
                    default: addr_n = addr_q + ADDR_W'(bus_byte) * LO_W;
                endcase
                cyc_n = cyc_q + 2'd1;
            end
        end else if (rd_stb) begin
            addr_n = addr_q + ADDR_W'(1);
        end
    end

    assign addr = addr_q;
    assign err  = err_q;
endmodule

// File: rtl/nand_chip_mem.sv
module nand_chip_mem #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nand_pair_emu.sv
module nand_pair_emu
    import nand_emu_pkg::*;
#(
    parameter  int MEM_BYTES = 1024,
    localparam int AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [13:0]   port_in,
    output logic [15:0]   port_out,
    output logic [15:0]   port_oe,
    output logic [1:0]    err,
    input  logic          ld_en,
    input  logic          ld_chip,
    input  logic [AW-1:0] ld_addr,
    input  logic [7:0]    ld_data
);
    localparam int NCHIP  = 2;
    localparam int ADDR_W = 32;

    logic [1:0]        cmd_stb;
    logic [1:0]        addr_stb;
    logic [1:0]        rd_stb;
    logic [1:0]        idle_stb;
    logic [7:0]        bus_byte;
    logic [ADDR_W-1:0] cur_addr [NCHIP];
    logic [7:0]        mem_q    [NCHIP];

    logic [7:0] rd_byte_q;
    logic       data_oe_q;
    logic [1:0] rdy_oe_q;

    nand_port_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_in  (port_in),
        .cmd_stb  (cmd_stb),
        .addr_stb (addr_stb),
        .rd_stb   (rd_stb),
        .idle_stb (idle_stb),
        .bus_byte (bus_byte)
    );

    for (genvar c = 0; c < NCHIP; c++) begin : g_chip
        nand_chip_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_stb  (cmd_stb[c]),
            .addr_stb (addr_stb[c]),
            .rd_stb   (rd_stb[c]),
            .bus_byte (bus_byte),
            .addr     (cur_addr[c]),
            .err      (err[c])
        );

        nand_chip_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ld_en && (ld_chip == 1'(c))),
            .wr_addr (ld_addr),
            .wr_data (ld_data),
            .rd_addr (cur_addr[c][AW-1:0]),
            .rd_data (mem_q[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_byte_q <= '0;
            data_oe_q <= 1'b0;
            rdy_oe_q  <= '0;
        end else begin
            if (|rd_stb) begin
                rd_byte_q <= rd_stb[1] ? mem_q[1] : mem_q[0];
                data_oe_q <= 1'b1;
            end else if (|idle_stb) begin
                data_oe_q <= 1'b0;
            end
            rdy_oe_q <= rdy_oe_q | idle_stb;
        end
    end

    assign port_out = {2'b11, 6'b0, rd_byte_q};
    assign port_oe  = {rdy_oe_q, 6'b0, {8{data_oe_q}}};
endmodule

// File: rtl/nand_pair_emu_chk.sv
module nand_pair_emu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] port_oe,
    input logic [1:0]  err,
    input logic [1:0]  rd_stb,
    input logic [1:0]  cmd_stb,
    input logic [1:0]  addr_stb,
    input logic [31:0] addr0
);
    AST_RDY_DIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(port_oe[14]) && !$fell(port_oe[15])); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(err[0]) && !$fell(err[1])); // R8

    AST_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_stb) |=> (port_oe[7:0] == 8'hFF)); // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb[0] && !cmd_stb[0] && !addr_stb[0]) |=> (addr0 == $past(addr0) + 32'd1)); // R6

    AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_stb | cmd_stb | addr_stb)); // R2
endmodule

bind nand_pair_emu nand_pair_emu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_oe  (port_oe),
    .err      (err),
    .rd_stb   (rd_stb),
    .cmd_stb  (cmd_stb),
    .addr_stb (addr_stb),
    .addr0    (cur_addr[0])
);

// File: tb/nand_pair_emu_tb_top.sv
`timescale 1ns/1ps
module nand_pair_emu_tb_top;
    localparam int AW = 10;
    localparam logic [1:0] SEL0 = 2'b10;
    localparam logic [1:0] SEL1 = 2'b01;
    localparam logic [1:0] SELB = 2'b00;
    localparam logic [1:0] SELN = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [13:0]   pin = 14'h0F00;
    logic [15:0]   port_out;
    logic [15:0]   port_oe;
    logic [1:0]    err;
    logic          ld_en = 1'b0;
    logic          ld_chip = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    nand_pair_emu dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_in  (pin),
        .port_out (port_out),
        .port_oe  (port_oe),
        .err      (err),
        .ld_en    (ld_en),
        .ld_chip  (ld_chip),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preload(input logic chip, input int a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_chip = chip; ld_addr = AW'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic latch(input logic [1:0] ce, input logic cle, input logic [7:0] b);
        @(negedge clk);
        pin[9:8] = ce; pin[13] = cle; pin[12] = ~cle; pin[7:0] = b;
        ticks(3);
        pin[11] = 1'b0;
        ticks(3);
        pin[11] = 1'b1;
        ticks(3);
        pin[13:12] = 2'b00;
    endtask

    task automatic send_addr3(input logic [1:0] ce, input logic [7:0] a0, a1, a2);
        latch(ce, 1'b0, a0);
        latch(ce, 1'b0, a1);
        latch(ce, 1'b0, a2);
    endtask

    task automatic read_byte(input logic [1:0] ce, output logic [7:0] v, output logic [7:0] oe);
        @(negedge clk);
        pin[9:8] = ce; pin[13:12] = 2'b00;
        ticks(3);
        pin[10] = 1'b0;
        ticks(3);
        v = port_out[7:0]; oe = port_oe[7:0];
        pin[10] = 1'b1;
        ticks(3);
    endtask

    task automatic t_reset_state();
        check("R1 reset oe", 32'(port_oe), 32'h0);
        check("R1 reset err", 32'(err), 32'h0);
    endtask

    task automatic t_ready();
        @(negedge clk); pin[9:8] = SEL0; ticks(4);
        check("R3 ready chip0 only", 32'(port_oe[15:14]), 32'h1);
        check("R3 ready level", 32'(port_out[15:14]), 32'h3);
        pin[9:8] = SEL1; ticks(4);
        check("R3 ready both", 32'(port_oe[15:14]), 32'h3);
    endtask

    task automatic t_mode1();
        logic [7:0] v, oe;
        latch(SEL0, 1'b1, 8'h00);
        send_addr3(SEL0, 8'h05, 8'h00, 8'h00);
        read_byte(SEL0, v, oe);
        check("R6 mode1 first byte", 32'(v), 32'hA5);
        check("R6 data driven", 32'(oe), 32'hFF);
        read_byte(SEL0, v, oe);
        check("R6 auto increment", 32'(v), 32'h5A);
        check("R3 data released", 32'(port_oe[7:0]), 32'h0);
        latch(SEL0, 1'b1, 8'h00);
        send_addr3(SEL0, 8'h40, 8'h00, 8'h00);
        read_byte(SEL0, v, oe);
        check("R7 erased byte", 32'(v), 32'hFF);
    endtask

    task automatic t_mode2_mode3();
        logic [7:0] v, oe;
        latch(SEL0, 1'b1, 8'h01);
        send_addr3(SEL0, 8'h03, 8'h00, 8'h00);
        read_byte(SEL0, v, oe);
        check("R4 R5 mode2 offset", 32'(v), 32'h33);
        latch(SEL0, 1'b1, 8'h50);
        send_addr3(SEL0, 8'h02, 8'h07, 8'h01);
        read_byte(SEL0, v, oe);
        check("R5 mode3 page and wrap", 32'(v), 32'h77);
    endtask

    task automatic t_two_chips();
        logic [7:0] v, oe;
        latch(SEL1, 1'b1, 8'h00);
        send_addr3(SEL1, 8'h05, 8'h00, 8'h00);
        read_byte(SEL1, v, oe);
        check("R2 chip1 read", 32'(v), 32'hC3);
        latch(SELB, 1'b1, 8'h00);
        send_addr3(SELB, 8'h06, 8'h00, 8'h00);
        read_byte(SELB, v, oe);
        check("R2 priority chip0", 32'(v), 32'h5A);
        read_byte(SEL1, v, oe);
        check("R9 chip1 untouched", 32'(v), 32'h3C);
    endtask

    task automatic t_ignored();
        logic [7:0] v, oe;
        latch(SELN, 1'b1, 8'h01);
        latch(SELN, 1'b0, 8'h10);
        read_byte(SELN, v, oe);
        read_byte(SEL0, v, oe);
        check("R2 deselected ignored", 32'(v), 32'h99);
        check("R2 no error", 32'(err), 32'h0);
    endtask

    task automatic t_errors();
        logic [7:0] v, oe;
        latch(SEL1, 1'b1, 8'hFF);
        latch(SEL1, 1'b0, 8'h01);
        check("R8 address in idle", 32'(err), 32'h2);
        read_byte(SEL1, v, oe);
        check("R8 idle addr unchanged", 32'(v), 32'h4B);
        latch(SEL0, 1'b1, 8'h01);
        latch(SEL0, 1'b1, 8'h90);
        check("R8 unknown command", 32'(err), 32'h3);
        send_addr3(SEL0, 8'h03, 8'h00, 8'h00);
        read_byte(SEL0, v, oe);
        check("R8 mode kept", 32'(v), 32'h33);
        latch(SEL0, 1'b1, 8'h00);
        send_addr3(SEL0, 8'h05, 8'h00, 8'h00);
        latch(SEL0, 1'b0, 8'h09);
        read_byte(SEL0, v, oe);
        check("R8 fourth address ignored", 32'(v), 32'hA5);
        check("R8 error sticky", 32'(err), 32'h3);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
        t_reset_state();
        preload(1'b0, 5, 8'hA5);
        preload(1'b0, 6, 8'h5A);
        preload(1'b0, 7, 8'h99);
        preload(1'b0, 259, 8'h33);
        preload(1'b0, 18, 8'h77);
        preload(1'b1, 5, 8'hC3);
        preload(1'b1, 6, 8'h3C);
        preload(1'b1, 7, 8'h4B);
        t_ready();
        t_mode1();
        t_mode2_mode3();
        t_two_chips();
        t_ignored();
        t_errors();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule